// File: doc/BRIEF.md
# Selective Prefix-Code Field Decoder

This block turns one coded instruction field into a plain field on each step. Its input is a window of buffered bits taken from a decode buffer. The window is left-aligned, so the oldest bit sits in the most significant position, and a count says how many of its bits are valid. A symbol opens with one flag bit. A clear flag means a prefix key from a small dictionary follows. A set flag means the field follows as raw bits, which lets rare values avoid having a dictionary entry. The dictionary is a parameter table of prefix-free keys of up to 8 bits, each with a symbol of the field width.

On every cycle in which the start enable is high, the block decodes the symbol at the head of the window. One clock later it presents the field, a valid strobe and the number of bits consumed. The surrounding buffer uses that count to shift its contents. If the window holds too few bits for the symbol at its head, the block reports nothing and waits. It raises an error flag when the window holds enough bits for the longest key and no key matches. A 32-bit instruction split into two 16-bit halves is decoded by two instances side by side.

Top module: `fdec_top`

## Requirements
- R1: With start_i high and the window's top bit (bit WIN_W-1) at 1, if avail_i >= FIELD_W+1, then one cycle later field_vld_o is 1, field_o equals window bits [WIN_W-2 -: FIELD_W] unchanged, and used_o is FIELD_W+1.
- R2: With start_i high and the top bit at 0, the bits that follow from bit WIN_W-2 downward are matched against the dictionary keys. Keys are stored left-aligned in 8 bits with a length of 1 to 8. The default keys are 0, 10, 110 and 11100101, with symbols 16'h0000, 16'h4000, 16'hE000 and 16'h1234. On a match with avail_i >= 1+length, the block shows one cycle later field_vld_o=1, field_o equal to the symbol, and used_o equal to 1+length.
- R3: When the symbol at the head needs more bits than avail_i gives, the next cycle shows field_vld_o=0, used_o=0 and err_o=0. This covers avail_i=0.
- R4: With the top bit at 0, avail_i >= 9 and no key matching, the next cycle shows err_o=1, field_vld_o=0 and used_o=0.
- R5: With start_i low, the next cycle shows field_vld_o=0, err_o=0 and used_o=0. field_o keeps its value whenever field_vld_o is 0.
- R6: Outputs change only on the clock edge that samples start_i, so results appear exactly one cycle after the inputs. At most one field is produced per cycle, and back-to-back starts give back-to-back results.
- R7: While rst_n is low, field_o, field_vld_o, used_o and err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Decode the symbol at the window head this cycle |
| win_i | input | WIN_W | Left-aligned bit window, oldest bit in the MSB |
| avail_i | input | $clog2(WIN_W+1) | Number of valid bits in win_i |
| field_o | output | FIELD_W | Decoded field, held while not valid |
| field_vld_o | output | 1 | field_o was produced this cycle |
| used_o | output | $clog2(WIN_W+1) | Bits consumed by the decoded symbol |
| err_o | output | 1 | No key matches a fully buffered key pattern |

## Verification
The hardest cases sit at the bit-count boundary, where the window has exactly one bit too few or exactly enough for a symbol. A raw field that needs FIELD_W+1 bits and an 8-bit key that needs 9 bits are the two cases where a wrong comparison slips through most easily. The stimulus builds windows whose head is a chosen key, a raw field or a pattern that matches no key, and then picks the valid count at random across the whole range. Directed cases pin the counts at the exact thresholds for each symbol kind.

// File: rtl/fdec_pkg.sv
package fdec_pkg;
  localparam int KEY_MAX = 8;
  localparam int KLEN_W  = 4;

  // Mask keeping the first len bits of a left-aligned key.
  function automatic logic [KEY_MAX-1:0] key_mask(input logic [KLEN_W-1:0] len);
    key_mask = ~({KEY_MAX{1'b1}} >> len);
  endfunction
endpackage

// File: rtl/fdec_match.sv
module fdec_match
  import fdec_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter logic [ENTRIES*KEY_MAX-1:0] KEYS  = '0,
  parameter logic [ENTRIES*KLEN_W-1:0]  KLENS = '0
) (
  input  logic [KEY_MAX-1:0] pat_i,
  output logic [ENTRIES-1:0] hit_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [KEY_MAX-1:0] KEY  = KEYS[e*KEY_MAX +: KEY_MAX];
    localparam logic [KLEN_W-1:0]  LEN  = KLENS[e*KLEN_W +: KLEN_W];
    localparam logic [KEY_MAX-1:0] MASK = key_mask(LEN);
    assign hit_o[e] = ((pat_i ^ KEY) & MASK) == '0;
  end
endmodule

// File: rtl/fdec_pick.sv
module fdec_pick
  import fdec_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int FIELD_W = 16,
  parameter logic [ENTRIES*KLEN_W-1:0]  KLENS = '0,
  parameter logic [ENTRIES*FIELD_W-1:0] SYMS  = '0
) (
  input  logic [ENTRIES-1:0] hit_i,
  output logic [FIELD_W-1:0] sym_o,
  output logic [KLEN_W-1:0]  klen_o,
  output logic               any_o
);
  always_comb begin
    sym_o  = '0;
    klen_o = '0;
    any_o  = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hit_i[e]) begin
        sym_o  = sym_o  | SYMS[e*FIELD_W +: FIELD_W];
        klen_o = klen_o | KLENS[e*KLEN_W +: KLEN_W];
        any_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fdec_top.sv
module fdec_top
  import fdec_pkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int WIN_W   = 24,
  parameter int ENTRIES = 4,
  parameter logic [ENTRIES*KEY_MAX-1:0] KEYS  = {8'hE5, 8'hC0, 8'h80, 8'h00},
  parameter logic [ENTRIES*KLEN_W-1:0]  KLENS = {4'd8, 4'd3, 4'd2, 4'd1},
  parameter logic [ENTRIES*FIELD_W-1:0] SYMS  = {16'h1234, 16'hE000, 16'h4000, 16'h0000}
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [WIN_W-1:0]             win_i,
  input  logic [$clog2(WIN_W+1)-1:0]   avail_i,
  output logic [FIELD_W-1:0]           field_o,
  output logic                         field_vld_o,
  output logic [$clog2(WIN_W+1)-1:0]   used_o,
  output logic                         err_o
);
  localparam int CNT_W = $clog2(WIN_W+1);
  localparam logic [CNT_W-1:0] RAW_LEN = CNT_W'(FIELD_W + 1);
  localparam logic [CNT_W-1:0] KEY_NEED = CNT_W'(KEY_MAX + 1);

  logic               flag;
  logic [KEY_MAX-1:0] pat;
  logic [ENTRIES-1:0] hit;
  logic [FIELD_W-1:0] sym;
  logic [KLEN_W-1:0]  klen;
  logic               any_hit;
  logic [CNT_W-1:0]   key_need;

  logic               vld_d, err_d;
  logic [FIELD_W-1:0] field_d;
  logic [CNT_W-1:0]   used_d;

  assign flag = win_i[WIN_W-1];
  assign pat  = win_i[WIN_W-2 -: KEY_MAX];

  fdec_match #(.ENTRIES(ENTRIES), .KEYS(KEYS), .KLENS(KLENS)) u_match (
    .pat_i (pat),
    .hit_o (hit)
  );

  fdec_pick #(.ENTRIES(ENTRIES), .FIELD_W(FIELD_W), .KLENS(KLENS), .SYMS(SYMS)) u_pick (
    .hit_i  (hit),
    .sym_o  (sym),
    .klen_o (klen),
    .any_o  (any_hit)
  );

  assign key_need = CNT_W'(klen) + CNT_W'(1);

  // Next-state logic
  always_comb begin
    vld_d   = 1'b0;
    err_d   = 1'b0;
    used_d  = '0;
    field_d = sym;
    if (start_i) begin
      if (flag) begin
        field_d = win_i[WIN_W-2 -: FIELD_W];
        if (avail_i >= RAW_LEN) begin
          vld_d  = 1'b1;
          used_d = RAW_LEN;
        end
      end else if (any_hit) begin
        if (avail_i >= key_need) begin
          vld_d  = 1'b1;
          used_d = key_need;
        end
      end else if (avail_i >= KEY_NEED) begin
        err_d = 1'b1;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_vld_o <= 1'b0;
      err_o       <= 1'b0;
      used_o      <= '0;
    end else begin
      field_vld_o <= vld_d;
      err_o       <= err_d;
      used_o      <= used_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_o <= '0;
    end else if (vld_d) begin
      field_o <= field_d;
    end
  end

  // Assertions
  // R2: a prefix-free dictionary never matches two keys at once
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  // R4: error and valid never together
  a_r4_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_o && field_vld_o));
  // R3: nothing consumed without a valid field
  a_r3_no_use_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !field_vld_o |-> used_o == '0);
  // R6: consumed bits never exceed what was buffered on the prior cycle
  a_r6_used_le_avail: assert property (@(posedge clk) disable iff (!rst_n)
    field_vld_o |-> used_o <= $past(avail_i));
  // R5: no output without a start on the prior cycle
  a_r5_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!field_vld_o && !err_o));
  // R1: raw field passes through unchanged with full length
  a_r1_raw_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && flag && avail_i >= RAW_LEN) |=>
      (field_vld_o && used_o == RAW_LEN && field_o == $past(win_i[WIN_W-2 -: FIELD_W])));
  // R5: field holds while not valid
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !field_vld_o |-> $stable(field_o));
endmodule

// File: tb/fdec_top_tb.sv
`timescale 1ns/1ps
module fdec_top_tb;
  localparam int FW = 16;
  localparam int WW = 24;
  localparam int CW = $clog2(WW+1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [WW-1:0] win_i;
  logic [CW-1:0] avail_i;
  logic [FW-1:0] field_o;
  logic          field_vld_o;
  logic [CW-1:0] used_o;
  logic          err_o;

  int checks = 0;
  int failures = 0;
  logic [FW-1:0] held = '0;

  logic [7:0]  tb_key [4] = '{8'h00, 8'h80, 8'hC0, 8'hE5};
  int          tb_len [4] = '{1, 2, 3, 8};
  logic [15:0] tb_sym [4] = '{16'h0000, 16'h4000, 16'hE000, 16'h1234};

  always #10 clk = ~clk;

  fdec_top u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .win_i(win_i), .avail_i(avail_i),
    .field_o(field_o), .field_vld_o(field_vld_o), .used_o(used_o), .err_o(err_o)
  );

  function automatic void ref_dec(input logic st, input logic [WW-1:0] w, input int av,
                                  output logic v, output logic e, output int u,
                                  output logic [FW-1:0] f, output string tag);
    v = 0; e = 0; u = 0; f = '0; tag = "R3";
    if (!st) begin tag = "R5"; return; end
    if (w[WW-1]) begin
      if (av >= FW+1) begin v = 1; u = FW+1; f = w[WW-2 -: FW]; tag = "R1"; end
      return;
    end
    for (int k = 0; k < 4; k++) begin
      logic m;
      m = 1;
      for (int i = 0; i < tb_len[k]; i++)
        if (w[WW-2-i] != tb_key[k][7-i]) m = 0;
      if (m) begin
        if (av >= 1 + tb_len[k]) begin v = 1; u = 1 + tb_len[k]; f = tb_sym[k]; tag = "R2"; end
        return;
      end
    end
    if (av >= 9) begin e = 1; tag = "R4"; end
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic st, input logic [WW-1:0] w, input int av);
    logic v, e; int u; logic [FW-1:0] f; string tag;
    ref_dec(st, w, av, v, e, u, f, tag);
    @(negedge clk);
    start_i = st; win_i = w; avail_i = CW'(av);
    @(negedge clk);
    if (v) held = f;
    check(tag, "vld", int'(field_vld_o), int'(v));
    check(tag, "err", int'(err_o), int'(e));
    check(tag, "used", int'(used_o), u);
    check(tag, "field", int'(field_o), int'(held));
  endtask

  function automatic logic [WW-1:0] with_key(input int k, input logic [WW-1:0] rnd);
    logic [WW-1:0] w;
    w = rnd;
    w[WW-1] = 1'b0;
    for (int i = 0; i < tb_len[k]; i++) w[WW-2-i] = tb_key[k][7-i];
    return w;
  endfunction

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; start_i = 1'b1; win_i = '1; avail_i = CW'(WW);
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", "vld", int'(field_vld_o), 0);
    check("R7", "err", int'(err_o), 0);
    check("R7", "used", int'(used_o), 0);
    check("R7", "field", int'(field_o), 0);
    start_i = 1'b0;
    rst_n = 1'b1;

    // R1: raw field at exact length and one short
    step(1, {1'b1, 16'hBEEF, 7'h55}, 17);
    step(1, {1'b1, 16'hCAFE, 7'h00}, 16);
    // R2: every key, each at exact length and one short
    for (int k = 0; k < 4; k++) begin
      step(1, with_key(k, WW'($urandom)), 1 + tb_len[k]);
      step(1, with_key(k, WW'($urandom)), tb_len[k]);
    end
    // R4: unmatched pattern 1111xxxx at 9 bits flags error, at 8 waits
    step(1, {1'b0, 8'hF3, 15'h0}, 9);
    step(1, {1'b0, 8'hF3, 15'h0}, 8);
    step(1, {1'b0, 8'hE4, 15'h0}, 24);
    // R3: empty window
    step(1, {1'b1, 23'h0}, 0);
    // R5: start low ignores a full raw window, field holds
    step(0, {1'b1, 16'h7777, 7'h0}, 24);

    // R6: result appears only after the sampling edge
    @(negedge clk);
    start_i = 1'b1; win_i = {1'b1, 16'hA5A5, 7'h0}; avail_i = CW'(24);
    #1 check("R6", "vld before edge", int'(field_vld_o), 0);
    @(negedge clk);
    check("R6", "vld after edge", int'(field_vld_o), 1);
    check("R6", "field after edge", int'(field_o), 16'hA5A5);
    held = 16'hA5A5;

    // Random mix, back-to-back starts (R1 R2 R3 R4 R5 R6)
    for (int n = 0; n < 3000; n++) begin
      logic [WW-1:0] w;
      int kind;
      w = WW'($urandom);
      kind = $urandom % 6;
      if (kind < 4) w = with_key(kind, w);
      else if (kind == 4) w[WW-1] = 1'b1;
      else begin w[WW-1] = 1'b0; w[WW-2 -: 4] = 4'hF; end
      step(($urandom % 8) != 0, w, $urandom % (WW + 1));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule